// File: doc/BRIEF.md
# Power Island Switch Sequencer

This block brings one switchable power island up or down on request. It drives a single 32-bit island control register, always by read-modify-write, and watches two status bits that the island reports back through the same register: power-good and memory-repair-done. The register itself, the analog power switches and the memory-repair engine all sit outside the block.

A power-up request first checks whether the switches are already closed. If they are, the sequence ends with no write. Otherwise the block closes the switches at the lowest inrush-current limit. It waits a bounded time for power-good and steps the limit up one level whenever that wait expires. Once power-good appears, it releases electrical isolation, requests memory repair, waits a bounded time for repair-done, and finally releases functional isolation. Each failure backs out exactly what had been enabled before it reports an error. A power-down request applies the three controls in reverse order, with no waits.

While a sequence runs, `busy` is high and new requests are dropped. The end of every sequence is marked by a one-cycle `done`, with `err` beside it when the sequence failed.

Top module: `pwr_island_seq`

## Requirements
- R1: Every register write carries the key 0x5A in bits 31:24. Bits 23:15 and 12:6 are written back exactly as they were read.
- R2: Field map: bit 0 closes the switches; bit 1 is power-good status; bit 2 set releases electrical isolation; bit 3 requests memory repair; bit 4 is repair-done status; bit 5 set releases functional isolation. Bits 14:13 hold the inrush code, where 0, 1, 2 and 3 select 3.5, 5, 10 and 20 mA.
- R3: A power-up request that finds bit 0 already set ends with `done` and `err` low, and issues no write.
- R4: Power-up tries inrush codes 0, 1, 2, 3 in that order. Each try is one write that sets bit 0 and the code. It is followed by a window of 3*CLK_MHZ cycles in which power-good is sampled. Power-good seen in the last cycle of a window counts as success.
- R5: Ramping stops at the first code that yields power-good, and that code stays in bits 14:13.
- R6: If no code yields power-good, one write clears bit 0 and bits 14:13, and the sequence ends with `err`. No other bit is changed.
- R7: After power-good, bit 2 is set, then bit 3 is set, then repair-done is awaited for up to 1*CLK_MHZ cycles, then bit 5 is set. The sequence ends without `err`.
- R8: If repair-done does not arrive in time, bit 2 is cleared, then bit 0 and bits 14:13 are cleared, and the sequence ends with `err`. Bit 3 stays set.
- R9: Power-down clears bit 5, then bit 2, then bit 0, one write each, with no status wait. It ends without `err`.
- R10: `busy` is high from the cycle after an accepted request until `done`. No write occurs while `busy` is low. Requests that arrive while `busy` is high are ignored.
- R11: When power-up and power-down are requested in the same idle cycle, power-up is performed.
- R12: `done` is a one-cycle pulse followed by idle, and `err` is high only together with `done`. After reset, `busy`, `done` and the write strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| onReq | input | 1 | Power-up request, sampled while idle |
| offReq | input | 1 | Power-down request, sampled while idle |
| regRdData | input | 32 | Current control register value including status bits |
| regWrEn | output | 1 | Register write strobe, one cycle per write |
| regWrData | output | 32 | Keyed write data |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Sequence finished (one cycle) |
| err | output | 1 | Sequence ended in a timeout (with done) |

## Verification
Two events can land in the same cycle: power-good arriving, and the expiry of a step's wait window. The bench arranges this by delaying the island model's power-good to exactly the last window cycle. It then checks that the code in force is kept and that the ramp does not move on. The same delay plus one cycle must instead push the ramp through every code and on to the error cleanup. The repair-done window is tested with the same pair of edge delays. Randomized runs mix these edge delays with random preserved register bits, and also raise both requests in the same cycle.

// File: rtl/pwr_island_pkg.sv
package pwr_island_pkg;

  localparam int RegW    = 32;
  localparam int SwBit   = 0;
  localparam int PgBit   = 1;
  localparam int EisoBit = 2;
  localparam int RepBit  = 3;
  localparam int RdnBit  = 4;
  localparam int FisoBit = 5;
  localparam int InrLo   = 13;
  localparam int InrW    = 2;
  localparam int KeyLo   = 24;
  localparam int KeyW    = 8;
  localparam logic [KeyW-1:0] KeyVal = 8'h5A;

  typedef enum logic [2:0] {
    OP_RAMP,
    OP_SET_EISO,
    OP_SET_REP,
    OP_SET_FISO,
    OP_CLR_EISO,
    OP_CLR_SW,
    OP_CLR_FISO,
    OP_CLR_POW
  } wrOp_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RAMP_WR,
    S_RAMP_WAIT,
    S_EISO_WR,
    S_REP_WR,
    S_REP_WAIT,
    S_FISO_WR,
    S_BACK_EISO,
    S_BACK_SW,
    S_DN_FISO,
    S_DN_EISO,
    S_DN_SW,
    S_FINISH
  } seqState_e;

  typedef struct packed {
    logic  wrEn;
    wrOp_e op;
    logic  codeClr;
    logic  codeInc;
    logic  tmrClr;
    logic  tmrRun;
    logic  tmrSel;
  } dpStrobe_t;

  typedef struct packed {
    logic pgSeen;
    logic repSeen;
    logic tmrExpired;
    logic codeLast;
    logic alreadyOn;
  } dpStatus_t;

endpackage

// File: rtl/pwr_island_dp.sv
module pwr_island_dp
  import pwr_island_pkg::*;
#(
  parameter int CLK_MHZ = 125,
  parameter int PG_US   = 3,
  parameter int RP_US   = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       stb,
  input  logic [RegW-1:0] regRdData,
  output dpStatus_t       sts,
  output logic            regWrEn,
  output logic [RegW-1:0] regWrData
);

  localparam int PgCyc  = CLK_MHZ * PG_US;
  localparam int RpCyc  = CLK_MHZ * RP_US;
  localparam int TmrMax = (PgCyc > RpCyc) ? PgCyc : RpCyc;
  localparam int TmrW   = $clog2(TmrMax + 1);
  localparam logic [TmrW-1:0] PgLim = TmrW'(PgCyc - 1);
  localparam logic [TmrW-1:0] RpLim = TmrW'(RpCyc - 1);

  logic [InrW-1:0] codeQ;
  logic [TmrW-1:0] tmrQ;
  logic [TmrW-1:0] tmrLim;
  logic [RegW-1:0] body;

  // inrush code register: cleared at sequence start, stepped on each retry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            codeQ <= '0;
    else if (stb.codeClr) codeQ <= '0;
    else if (stb.codeInc) codeQ <= codeQ + 1'b1;
  end

  // one wait counter shared by the power-good and repair windows
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           tmrQ <= '0;
    else if (stb.tmrClr) tmrQ <= '0;
    else if (stb.tmrRun) tmrQ <= tmrQ + 1'b1;
  end

  assign tmrLim = stb.tmrSel ? RpLim : PgLim;

  always_comb begin
    sts.pgSeen     = regRdData[PgBit];
    sts.repSeen    = regRdData[RdnBit];
    sts.alreadyOn  = regRdData[SwBit];
    sts.tmrExpired = (tmrQ == tmrLim);
    sts.codeLast   = &codeQ;
  end

  // read-modify-write data: live value, one field changed, key on top
  always_comb begin
    body = regRdData;
    unique case (stb.op)
      OP_RAMP: begin
        body[InrLo +: InrW] = codeQ;
        body[SwBit]         = 1'b1;
      end
      OP_SET_EISO: body[EisoBit] = 1'b1;
      OP_SET_REP:  body[RepBit]  = 1'b1;
      OP_SET_FISO: body[FisoBit] = 1'b1;
      OP_CLR_EISO: body[EisoBit] = 1'b0;
      OP_CLR_SW: begin
        body[InrLo +: InrW] = '0;
        body[SwBit]         = 1'b0;
      end
      OP_CLR_FISO: body[FisoBit] = 1'b0;
      OP_CLR_POW:  body[SwBit]   = 1'b0;
      default: body = regRdData;
    endcase
    body[KeyLo +: KeyW] = KeyVal;
  end

  assign regWrEn   = stb.wrEn;
  assign regWrData = body;

endmodule

// File: rtl/pwr_island_ctrl.sv
module pwr_island_ctrl
  import pwr_island_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      onReq,
  input  logic      offReq,
  input  dpStatus_t sts,
  output dpStrobe_t stb,
  output logic      busy,
  output logic      done,
  output logic      err
);

  seqState_e stateQ, stateNxt;
  logic      errQ, errSet, errClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateNxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       errQ <= 1'b0;
    else if (errClr) errQ <= 1'b0;
    else if (errSet) errQ <= 1'b1;
  end

  always_comb begin
    stateNxt = stateQ;
    stb      = '0;
    stb.op   = OP_RAMP;
    errSet   = 1'b0;
    errClr   = 1'b0;
    unique case (stateQ)
      S_IDLE: begin
        if (onReq) begin
          errClr = 1'b1;
          if (sts.alreadyOn) begin
            stateNxt = S_FINISH;
          end else begin
            stb.codeClr = 1'b1;
            stateNxt    = S_RAMP_WR;
          end
        end else if (offReq) begin
          errClr   = 1'b1;
          stateNxt = S_DN_FISO;
        end
      end
      S_RAMP_WR: begin
        stb.wrEn   = 1'b1;
        stb.op     = OP_RAMP;
        stb.tmrClr = 1'b1;
        stateNxt   = S_RAMP_WAIT;
      end
      S_RAMP_WAIT: begin
        if (sts.pgSeen) begin
          stateNxt = S_EISO_WR;
        end else if (sts.tmrExpired) begin
          if (sts.codeLast) begin
            errSet   = 1'b1;
            stateNxt = S_BACK_SW;
          end else begin
            stb.codeInc = 1'b1;
            stateNxt    = S_RAMP_WR;
          end
        end else begin
          stb.tmrRun = 1'b1;
        end
      end
      S_EISO_WR: begin
        stb.wrEn = 1'b1;
        stb.op   = OP_SET_EISO;
        stateNxt = S_REP_WR;
      end
      S_REP_WR: begin
        stb.wrEn   = 1'b1;
        stb.op     = OP_SET_REP;
        stb.tmrClr = 1'b1;
        stb.tmrSel = 1'b1;
        stateNxt   = S_REP_WAIT;
      end
      S_REP_WAIT: begin
        stb.tmrSel = 1'b1;
        if (sts.repSeen) begin
          stateNxt = S_FISO_WR;
        end else if (sts.tmrExpired) begin
          errSet   = 1'b1;
          stateNxt = S_BACK_EISO;
        end else begin
          stb.tmrRun = 1'b1;
        end
      end
      S_FISO_WR: begin
        stb.wrEn = 1'b1;
        stb.op   = OP_SET_FISO;
        stateNxt = S_FINISH;
      end
      S_BACK_EISO: begin
        stb.wrEn = 1'b1;
        stb.op   = OP_CLR_EISO;
        stateNxt = S_BACK_SW;
      end
      S_BACK_SW: begin
        stb.wrEn = 1'b1;
        stb.op   = OP_CLR_SW;
        stateNxt = S_FINISH;
      end
      S_DN_FISO: begin
        stb.wrEn = 1'b1;
        stb.op   = OP_CLR_FISO;
        stateNxt = S_DN_EISO;
      end
      S_DN_EISO: begin
        stb.wrEn = 1'b1;
        stb.op   = OP_CLR_EISO;
        stateNxt = S_DN_SW;
      end
      S_DN_SW: begin
        stb.wrEn = 1'b1;
        stb.op   = OP_CLR_POW;
        stateNxt = S_FINISH;
      end
      S_FINISH: stateNxt = S_IDLE;
      default:  stateNxt = S_IDLE;
    endcase
  end

  assign busy = (stateQ != S_IDLE);
  assign done = (stateQ == S_FINISH);
  assign err  = done & errQ;

endmodule

// File: rtl/pwr_island_seq.sv
module pwr_island_seq #(
  parameter int CLK_MHZ = 125,
  parameter int PG_US   = 3,
  parameter int RP_US   = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        onReq,
  input  logic        offReq,
  input  logic [31:0] regRdData,
  output logic        regWrEn,
  output logic [31:0] regWrData,
  output logic        busy,
  output logic        done,
  output logic        err
);

  import pwr_island_pkg::*;

  dpStrobe_t stb;
  dpStatus_t sts;

  pwr_island_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .onReq  (onReq),
    .offReq (offReq),
    .sts    (sts),
    .stb    (stb),
    .busy   (busy),
    .done   (done),
    .err    (err)
  );

  pwr_island_dp #(
    .CLK_MHZ (CLK_MHZ),
    .PG_US   (PG_US),
    .RP_US   (RP_US)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .regRdData (regRdData),
    .sts       (sts),
    .regWrEn   (regWrEn),
    .regWrData (regWrData)
  );

endmodule

// File: rtl/pwr_island_seq_chk.sv
module pwr_island_seq_chk
  import pwr_island_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        onReq,
  input logic        offReq,
  input logic [31:0] regRdData,
  input logic        regWrEn,
  input logic [31:0] regWrData,
  input logic        busy,
  input logic        done,
  input logic        err
);

  p_key_present_r1: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> regWrData[KeyLo +: KeyW] == KeyVal);

  p_preserve_r1: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regWrData[23:15] == regRdData[23:15]) && (regWrData[12:6] == regRdData[12:6]));

  // inrush code only ever steps up by one while the switches stay closed
  p_ramp_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[SwBit] && regRdData[SwBit] &&
     (regWrData[InrLo +: InrW] != regRdData[InrLo +: InrW]))
    |-> regWrData[InrLo +: InrW] == regRdData[InrLo +: InrW] + 2'd1);

  p_eiso_after_pg_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[EisoBit] && !regRdData[EisoBit]) |-> regRdData[PgBit]);

  p_fiso_after_rep_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[FisoBit] && !regRdData[FisoBit]) |-> regRdData[RdnBit]);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !regWrEn);

  p_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (onReq || offReq)) |=> busy);

  p_err_with_done_r12: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

endmodule

bind pwr_island_seq pwr_island_seq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .onReq     (onReq),
  .offReq    (offReq),
  .regRdData (regRdData),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .busy      (busy),
  .done      (done),
  .err       (err)
);

// File: tb/pwr_island_seq_test.sv
module pwr_island_seq_test;

  localparam int MHZ   = 125;
  localparam int PGC   = MHZ * 3;
  localparam int RPC   = MHZ * 1;
  localparam logic [31:0] WMASK = 32'h00FF_FFED;
  localparam logic [31:0] INRM  = 32'h0000_6000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic onReq = 1'b0, offReq = 1'b0;
  logic [31:0] regRdData;
  logic regWrEn;
  logic [31:0] regWrData;
  logic busy, done, err;

  always #4 clk = ~clk;

  pwr_island_seq #(.CLK_MHZ(MHZ)) uut (
    .clk(clk), .rstN(rstN), .onReq(onReq), .offReq(offReq),
    .regRdData(regRdData), .regWrEn(regWrEn), .regWrData(regWrData),
    .busy(busy), .done(done), .err(err)
  );

  // ---------------- island and register stub ----------------
  logic [31:0] regQ;
  logic        loadEn = 1'b0;
  logic [31:0] loadVal = '0;
  int pgMin = 0, pgDly = 0, rpDly = 0;
  int pgCnt, rpCnt, wrCount, badKey;
  int chg [0:5];
  logic pwrGood, repDone;

  assign pwrGood = regQ[0] && (int'(regQ[14:13]) >= pgMin) && (pgCnt >= pgDly);
  assign repDone = regQ[3] && (rpCnt >= rpDly);
  assign regRdData = {8'h00, regQ[23:5], repDone, regQ[3:2], pwrGood, regQ[0]};

  always @(posedge clk) begin
    if (loadEn) begin
      regQ <= loadVal & WMASK;
      pgCnt <= 0; rpCnt <= 0; wrCount <= 0; badKey <= 0;
      for (int k = 0; k < 6; k++) chg[k] <= -1;
    end else begin
      if (regWrEn) begin
        wrCount <= wrCount + 1;
        pgCnt <= 0;
        rpCnt <= 0;
        if (regWrData[31:24] == 8'h5A) begin
          regQ <= regWrData & WMASK;
          for (int k = 0; k < 6; k++)
            if (regWrData[k] != regQ[k]) chg[k] <= wrCount;
        end else begin
          badKey <= badKey + 1;
        end
      end else begin
        pgCnt <= (regQ[0] && int'(regQ[14:13]) >= pgMin) ? pgCnt + 1 : 0;
        rpCnt <= regQ[3] ? rpCnt + 1 : 0;
      end
    end
  end

  // ---------------- bench bookkeeping ----------------
  int nChk = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic loadState(input logic [31:0] init, input int mn, input int d, input int r);
    @(negedge clk);
    loadEn = 1'b1; loadVal = init; pgMin = mn; pgDly = d; rpDly = r;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  // request, then count negedges until done; midOn>0 pulses onReq mid-sequence
  task automatic runSeq(input bit doOn, input bit doOff, input int midOn,
                        output int cyc, output bit errSeen, output bit busyMid);
    @(negedge clk);
    onReq = doOn; offReq = doOff;
    cyc = 0; errSeen = 0; busyMid = 0;
    forever begin
      @(negedge clk);
      onReq = 1'b0; offReq = 1'b0;
      cyc++;
      if (cyc == midOn) begin busyMid = busy; onReq = 1'b1; end
      if (done) begin errSeen = err; break; end
      if (cyc > 5000) begin
        chk(0, "R12", "done never seen", cyc, 0);
        break;
      end
    end
    onReq = 1'b0;
    @(negedge clk);
    chk(!done && !busy, "R12", "done pulse then idle", {done, busy}, 0);
  endtask

  // expected outcome of a sequence, from the requirements
  task automatic predict(input bit up, input logic [31:0] init, input int mn,
                         input int d, input int r, output logic [31:0] fin,
                         output bit e, output int nw, output string tag);
    logic [31:0] v;
    v = init & WMASK;
    if (!up) begin
      fin = v & ~32'h25; e = 0; nw = 3; tag = "R9";
    end else if (v[0]) begin
      fin = v; e = 0; nw = 0; tag = "R3";
    end else if (mn > 3 || d > PGC - 1) begin
      fin = v & ~(INRM | 32'h1); e = 1; nw = 5; tag = "R6";
    end else begin
      v = (v & ~INRM) | (32'(mn) << 13) | 32'h0D;
      if (r <= RPC - 1) begin
        fin = v | 32'h20; e = 0; nw = mn + 4; tag = "R7";
      end else begin
        fin = v & ~(INRM | 32'h5); e = 1; nw = mn + 5; tag = "R8";
      end
    end
  endtask

  task automatic scenario(input bit up, input bit both, input logic [31:0] init,
                          input int mn, input int d, input int r, output int cyc);
    logic [31:0] fin; bit e, es, bm; int nw; string tag;
    predict(up || both, init, mn, d, r, fin, e, nw, tag);
    loadState(init, mn, d, r);
    runSeq(up || both, !up || both, 0, cyc, es, bm);
    chk(regQ == fin, tag, "final register", regQ, fin);
    chk(es == e, tag, "err at done", es, e);
    chk(wrCount == nw, tag, "write count", wrCount, nw);
    chk(badKey == 0, "R1", "writes without key", badKey, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int cyc; bit es, bm;
    void'($urandom(32'd1234));
    loadState(32'h0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy && !done && !regWrEn, "R12", "reset outputs", {busy, done, regWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R7/R2: plain power-up, order of releases
    scenario(1, 0, 32'h0, 0, 0, 0, cyc);
    chk(chg[0] < chg[2] && chg[2] < chg[3] && chg[3] < chg[5], "R7", "release order",
        {chg[0][7:0], chg[2][7:0], chg[3][7:0], chg[5][7:0]}, 32'h00010203);

    // R4/R5: power-good in the last cycle of the window at code 2 wins over expiry
    scenario(1, 0, 32'h0080_8040, 2, PGC - 1, RPC - 1, cyc);
    chk(regQ[14:13] == 2'd2, "R5", "kept inrush code", regQ[14:13], 2);

    // R3: already on, nothing written
    scenario(1, 0, 32'h00A0_4025, 0, 0, 0, cyc);

    // R9: power-down order and no waits
    scenario(0, 0, 32'h0012_602D, 0, 0, 0, cyc);
    chk(chg[5] < chg[2] && chg[2] < chg[0], "R9", "clear order",
        {chg[5][7:0], chg[2][7:0], chg[0][7:0]}, 32'h000102);
    chk(cyc <= 5, "R9", "down cycles", cyc, 4);

    // R6/R4: never good; each step waits its full window
    scenario(1, 0, 32'h00F0_0F00, 4, 0, 0, cyc);
    chk(cyc >= 4 * PGC && cyc <= 4 * PGC + 8, "R4", "ramp window length", cyc, 4 * PGC + 6);

    // R6: power-good one cycle too late at every code
    scenario(1, 0, 32'h0000_0024, 1, PGC, 0, cyc);

    // R8: repair-done misses its window by one cycle
    scenario(1, 0, 32'h0001_0000, 0, 0, RPC, cyc);
    chk(cyc >= RPC && cyc <= RPC + 10, "R8", "repair window length", cyc, RPC + 6);

    // R11: both requests together, power-up wins
    scenario(1, 1, 32'h0, 1, 3, 5, cyc);
    chk(regQ[0] == 1'b1, "R11", "switch closed", regQ[0], 1);

    // R10: power-up request during a power-down is ignored
    loadState(32'h0000_0025, 0, 0, 0);
    runSeq(0, 1, 2, cyc, es, bm);
    chk(bm == 1'b1, "R10", "busy mid-sequence", bm, 1);
    chk(regQ == 32'h0, "R10", "final after ignored request", regQ, 0);
    chk(wrCount == 3, "R10", "write count", wrCount, 3);
    repeat (4) @(negedge clk);
    chk(!busy && wrCount == 3, "R10", "no late start", {busy, wrCount[7:0]}, 3);

    // randomized mix
    for (int i = 0; i < 40; i++) begin
      logic [31:0] init; bit up, both; int mn, d, r, sel;
      up = $urandom_range(1, 0) == 1;
      both = up && ($urandom_range(4, 0) == 0);
      init = $urandom & WMASK;
      if (up) init[0] = ($urandom_range(5, 0) == 0);
      mn = $urandom_range(4, 0);
      sel = $urandom_range(3, 0);
      d = (sel == 0) ? 0 : (sel == 1) ? PGC - 1 : (sel == 2) ? PGC : $urandom_range(PGC - 1, 0);
      sel = $urandom_range(3, 0);
      r = (sel == 0) ? 0 : (sel == 1) ? RPC - 1 : (sel == 2) ? RPC : $urandom_range(RPC - 1, 0);
      scenario(up, both, init, mn, d, r, cyc);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule